// File: doc/BRIEF.md
# Strobed Row/Column Memory Array, Eight Lanes Wide

This block is a synchronous behavioural model of a small dynamic-memory-style storage array. Each lane holds a square grid of byte-wide cells. A lane is not reached through a flat address. A row strobe first opens one row: the row index is taken from a narrow address bus that is shared with the column index, and the whole row is copied into a per-lane row buffer. Later column strobes then pick one cell of that buffer, either to read it out or to overwrite it. A write changes both the buffer and the stored row, so the two never disagree.

Eight lanes sit side by side behind one strobe controller. Every lane sees the same row and column strobes in the same cycle, and lane k owns bits 8k+7 down to 8k of the 64-bit word. The row stays open until the next row strobe, so any number of column accesses can be served from it. A column strobe that arrives while no row is open is refused and flagged. Reset closes the row but leaves the stored data alone.

Top module: `strobed_mem_wide`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, rdata_valid and col_err are 0, rdata is 0 and no row is open.
- R2: A cycle with row_strb high opens the row given by addr[1:0] and copies that row of every lane into the lane's row buffer, replacing any row opened before.
- R3: A cycle with col_strb high, wr_en low, row_strb low and a row open is a read. On the next cycle rdata_valid is 1 and rdata[8k+7:8k] holds cell (open row, addr) of lane k, for k from 0 to 7.
- R4: A cycle with col_strb high, wr_en high, row_strb low and a row open writes wdata[8k+7:8k] into cell (open row, addr) of lane k. A later read of that cell returns the new value, both from the same open row and after the row has been closed and reopened.
- R5: A column strobe while no row is open changes no cell and no row buffer. On the next cycle col_err is 1 for one cycle and rdata_valid is 0.
- R6: An open row stays open across any number of column strobes. Reads of different columns, in any order, are served without a new row strobe.
- R7: When row_strb and col_strb are high in the same cycle, the row strobe is carried out and the column access is refused. No cell is written and col_err is 1 on the next cycle.
- R8: Reset does not change stored cells. Data written before a reset reads back unchanged afterwards once a row has been opened.
- R9: An accepted write leaves rdata_valid at 0 on the next cycle and leaves rdata holding its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset; closes the open row and clears the flags |
| row_strb | input | 1 | Single-cycle row strobe; opens the row given by addr |
| col_strb | input | 1 | Single-cycle column strobe; reads or writes the column given by addr |
| wr_en | input | 1 | Sampled with col_strb; 1 selects a write, 0 a read |
| addr | input | 2 | Shared address bus; carries a row index with row_strb and a column index with col_strb |
| wdata | input | 64 | Write word; lane k takes bits 8k+7:8k |
| rdata | output | 64 | Read word, registered; lane k drives bits 8k+7:8k |
| rdata_valid | output | 1 | High for the one cycle after an accepted read |
| col_err | output | 1 | High for the one cycle after a refused column strobe |

## Verification
The assertions assume that reset is held low from time zero through the first rising edge, so that every $past they use sees defined, reset-time values. They also assume that wr_en matters only in a cycle with a column strobe, and that the stored cells can hold any value before the first write. The stimulus drives every strobe as a single-cycle pulse changed on the falling clock edge. It fills every cell before it reads any of them, so each expected value comes from the bench's own model of the grid and never from data left over from power-up.

// File: rtl/strobed_mem_pkg.sv
package strobed_mem_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_ROW,
    CMD_ROW_REFUSE,
    CMD_READ,
    CMD_WRITE,
    CMD_REFUSE
  } strobe_cmd_e;

  // Priority: a row strobe always wins; a column strobe needs an open row
  // and no row strobe in the same cycle.
  function automatic strobe_cmd_e decode_strobe(input logic row_s,
                                                input logic col_s,
                                                input logic we,
                                                input logic opened);
    strobe_cmd_e cmd;
    if (row_s)            cmd = col_s ? CMD_ROW_REFUSE : CMD_ROW;
    else if (!col_s)      cmd = CMD_IDLE;
    else if (!opened)     cmd = CMD_REFUSE;
    else                  cmd = we ? CMD_WRITE : CMD_READ;
    return cmd;
  endfunction

  function automatic logic cmd_loads_row(input strobe_cmd_e cmd);
    return (cmd == CMD_ROW) || (cmd == CMD_ROW_REFUSE);
  endfunction

  function automatic logic cmd_refuses(input strobe_cmd_e cmd);
    return (cmd == CMD_REFUSE) || (cmd == CMD_ROW_REFUSE);
  endfunction

endpackage

// File: rtl/strobed_mem_ctrl.sv
module strobed_mem_ctrl
  import strobed_mem_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_strb,
  input  logic              col_strb,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              row_load,
  output logic              col_read,
  output logic              col_write,
  output logic [ADDR_W-1:0] open_row,
  output logic              row_open,
  output logic              rd_valid,
  output logic              col_err
);

  strobe_cmd_e cmd;
  logic        col_refuse;

  always_comb begin
    cmd        = decode_strobe(row_strb, col_strb, wr_en, row_open);
    row_load   = cmd_loads_row(cmd);
    col_refuse = cmd_refuses(cmd);
    col_read   = (cmd == CMD_READ);
    col_write  = (cmd == CMD_WRITE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      open_row <= '0;
      rd_valid <= 1'b0;
      col_err  <= 1'b0;
    end else begin
      rd_valid <= col_read;
      col_err  <= col_refuse;
      if (row_load) begin
        row_open <= 1'b1;
        open_row <= addr;
      end
    end
  end

  // R2
  row_open_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_strb |=> row_open && (open_row == $past(addr)));

  // R6
  open_row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !row_strb |=> $stable(open_row));

  // R3
  rd_valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(col_strb && !wr_en && !row_strb));

  // R5
  col_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_err |-> $past(col_strb));

  // R5
  err_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(col_err && rd_valid));

  // R7
  both_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_strb && col_strb) |=> col_err && !rd_valid);

endmodule

// File: rtl/strobed_mem_lane.sv
module strobed_mem_lane #(
  parameter int SIDE   = 4,
  parameter int CELL_W = 8,
  parameter int ADDR_W = (SIDE > 1) ? $clog2(SIDE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_load,
  input  logic              col_read,
  input  logic              col_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] open_row,
  input  logic [CELL_W-1:0] wdata,
  output logic [CELL_W-1:0] rdata
);

  logic [CELL_W-1:0] grid    [SIDE][SIDE];
  logic [CELL_W-1:0] row_buf [SIDE];

  // Storage: not reset, written only by an accepted column write.
  always_ff @(posedge clk) begin
    if (col_write) grid[open_row][addr] <= wdata;
  end

  // Row buffer: filled by a row strobe, patched by a write.
  always_ff @(posedge clk) begin
    if (row_load) begin
      for (int c = 0; c < SIDE; c++) row_buf[c] <= grid[addr][c];
    end else if (col_write) begin
      row_buf[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        rdata <= '0;
    else if (col_read) rdata <= row_buf[addr];
  end

  // R2
  row_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_load |=> row_buf[0] == grid[$past(addr)][0]);

  // R4
  write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_write |=> grid[$past(open_row)][$past(addr)] == $past(wdata));

  // R4
  write_coherent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_write |=> row_buf[$past(addr)] == grid[$past(open_row)][$past(addr)]);

  // R9
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_write |=> $stable(rdata));

endmodule

// File: rtl/strobed_mem_wide.sv
module strobed_mem_wide #(
  parameter int SIDE   = 4,
  parameter int CELL_W = 8,
  parameter int LANES  = 8,
  parameter int ADDR_W = (SIDE > 1) ? $clog2(SIDE) : 1,
  parameter int WORD_W = CELL_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_strb,
  input  logic              col_strb,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rdata_valid,
  output logic              col_err
);

  logic              row_load;
  logic              col_read;
  logic              col_write;
  logic              row_open;
  logic [ADDR_W-1:0] open_row;

  strobed_mem_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_strb (row_strb),
    .col_strb (col_strb),
    .wr_en    (wr_en),
    .addr     (addr),
    .row_load (row_load),
    .col_read (col_read),
    .col_write(col_write),
    .open_row (open_row),
    .row_open (row_open),
    .rd_valid (rdata_valid),
    .col_err  (col_err)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    strobed_mem_lane #(
      .SIDE  (SIDE),
      .CELL_W(CELL_W),
      .ADDR_W(ADDR_W)
    ) lane_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .row_load (row_load),
      .col_read (col_read),
      .col_write(col_write),
      .addr     (addr),
      .open_row (open_row),
      .wdata    (wdata[k*CELL_W +: CELL_W]),
      .rdata    (rdata[k*CELL_W +: CELL_W])
    );
  end

  // R5
  no_access_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !row_open |-> !col_read && !col_write);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !rdata_valid && !col_err && !row_open && (rdata == '0));

endmodule

// File: tb/strobed_mem_wide_tb.sv
`timescale 1ns/1ps
module strobed_mem_wide_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        row_strb = 1'b0;
  logic        col_strb = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        rdata_valid;
  logic        col_err;

  int tests = 0;
  int failed = 0;
  logic [63:0] model [4][4];

  always #10 clk = ~clk;

  strobed_mem_wide dut_i (
    .clk(clk), .rst_n(rst_n), .row_strb(row_strb), .col_strb(col_strb),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_valid(rdata_valid), .col_err(col_err)
  );

  // Byte k of cell (r,c): k*32 + r*8 + c*2 + salt; unique per lane/cell.
  function automatic logic [63:0] pat(int r, int c, int salt);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[k*8 +: 8] = 8'((k*32 + r*8 + c*2 + salt) & 255);
    return w;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the capture.
  task automatic pulse(logic rs, logic cs, logic we, logic [1:0] a, logic [63:0] d);
    row_strb = rs; col_strb = cs; wr_en = we; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    row_strb = 1'b0; col_strb = 1'b0; wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; failed++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    logic [63:0] held;
    do_reset();
    // R1: right after reset
    check("R1 rdata_valid", 64'(rdata_valid), 64'd0);
    check("R1 col_err", 64'(col_err), 64'd0);
    check("R1 rdata", rdata, 64'd0);
    // R1/R5: no row open, column read refused
    pulse(0, 1, 0, 2'd1, '0);
    check("R5 col_err closed read", 64'(col_err), 64'd1);
    check("R5 no valid on refused read", 64'(rdata_valid), 64'd0);
    check("R5 rdata kept", rdata, 64'd0);
    @(negedge clk);
    check("R5 col_err single pulse", 64'(col_err), 64'd0);

    // Fill every cell (R4)
    for (int r = 0; r < 4; r++) begin
      pulse(1, 0, 0, 2'(r), '0);
      for (int c = 0; c < 4; c++) begin
        model[r][c] = pat(r, c, 1);
        pulse(0, 1, 1, 2'(c), model[r][c]);
        check("R9 no valid after write", 64'(rdata_valid), 64'd0);
      end
    end

    // Read sweep, reverse column order then column 0 again (R2, R3, R6)
    for (int r = 0; r < 4; r++) begin
      pulse(1, 0, 0, 2'(r), '0);
      for (int c = 3; c >= 0; c--) begin
        pulse(0, 1, 0, 2'(c), '0);
        check("R3 read valid", 64'(rdata_valid), 64'd1);
        check("R3 read data", rdata, model[r][c]);
      end
      pulse(0, 1, 0, 2'd0, '0);
      check("R6 reread open row", rdata, model[r][0]);
    end

    // Write then read in the same open row, then after reopening (R4)
    pulse(1, 0, 0, 2'd2, '0);
    model[2][1] = ~pat(2, 1, 0);
    pulse(0, 1, 1, 2'd1, model[2][1]);
    pulse(0, 1, 0, 2'd1, '0);
    check("R4 read after write same row", rdata, model[2][1]);
    held = rdata;
    // R9: write leaves rdata unchanged
    model[2][3] = ~pat(2, 3, 0);
    pulse(0, 1, 1, 2'd3, model[2][3]);
    check("R9 rdata held on write", rdata, held);
    check("R9 valid low on write", 64'(rdata_valid), 64'd0);
    pulse(1, 0, 0, 2'd0, '0);
    pulse(0, 1, 0, 2'd1, '0);
    check("R2 new row replaces old", rdata, model[0][1]);
    pulse(1, 0, 0, 2'd2, '0);
    pulse(0, 1, 0, 2'd1, '0);
    check("R4 read after reopen", rdata, model[2][1]);
    pulse(0, 1, 0, 2'd3, '0);
    check("R4 second write after reopen", rdata, model[2][3]);

    // R7: both strobes, row 3 opens, column write refused
    pulse(1, 1, 1, 2'd3, 64'hDEAD_BEEF_0BAD_F00D);
    check("R7 col_err on both strobes", 64'(col_err), 64'd1);
    check("R7 no valid", 64'(rdata_valid), 64'd0);
    for (int c = 0; c < 4; c++) begin
      pulse(0, 1, 0, 2'(c), '0);
      check("R7 row 3 opened, unchanged", rdata, model[3][c]);
    end

    // R8/R5: reset keeps data; write with no open row is refused
    do_reset();
    check("R1 rdata after reset", rdata, 64'd0);
    pulse(0, 1, 1, 2'd2, 64'h0123_4567_89AB_CDEF);
    check("R5 col_err closed write", 64'(col_err), 64'd1);
    pulse(1, 0, 0, 2'd1, '0);
    for (int c = 0; c < 4; c++) begin
      pulse(0, 1, 0, 2'(c), '0);
      check("R8 data kept across reset", rdata, model[1][c]);
    end
    pulse(1, 0, 0, 2'd0, '0);
    pulse(0, 1, 0, 2'd2, '0);
    check("R5 refused write left cell", rdata, model[0][2]);

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule